// File: doc/BRIEF.md
# Storage key reference/change updater

This block keeps one key byte per page of absolute storage and updates it after an access has been translated. Each request carries an absolute address, an access kind and the permission flags produced so far. The block looks up the key of the page that holds the address, records that the page was referenced and, for stores, that it was changed. It then returns the flags, possibly with write permission removed.

Removing write permission on a load or fetch to a page whose change bit is still clear means a cached translation cannot later be reused for a store. That store has to come back through this block, and the change bit is recorded at that point. Accesses beyond the configured storage size and translation-table reads leave the keys untouched.

A separate host port reads and writes any key directly. A host write that lands on the page being written back in the same cycle wins over the update. Requests are fully pipelined: a new one may be presented every cycle.

Top module: `skey_rc_updater`

## Requirements
- R1: After reset every key byte is 0x00, `rsp_done` is low, `rsp_flags` is 0 and `host_rdata` is 0.
- R2: The key selected by a request is the one at page number `req_addr >> PAGE_BITS`. The byte offset within the page does not affect which key is used.
- R3: A request whose page number is at or above `mem_pages` changes no key and returns `req_flags` unchanged.
- R4: Key byte layout: bits [7:4] access control, bit 3 fetch protection, bit 2 reference, bit 1 change, bit 0 reserved. Every load (`req_kind` 00), store (01) or fetch (10) that reaches the update sets bit 2 and leaves bits [7:3] and bit 0 as they were.
- R5: A store that reaches the update sets bit 1 of the key and returns `req_flags` unchanged.
- R6: Flags are bit 0 read, bit 1 write, bit 2 execute. A load or fetch that reaches the update clears bit 1 of the returned flags when the key's change bit is clear. It returns the flags unchanged when the change bit is set.
- R7: A page below `mem_pages` but at or above `KEY_PAGES` has no key storage and counts as a key read error. No key is written, no other page's key aliases to it, and the flags pass through unchanged.
- R8: A translation-table read (`req_kind` 11) changes no key and returns `req_flags` unchanged.
- R9: A request presented in cycle N produces exactly one `rsp_done` pulse in cycle N+2. Requests in consecutive cycles each get their own pulse. Each request sees the key as updated by the request before it.
- R10: A host write in the cycle in which a request's key is written back takes priority when it targets the same page, and the write-back is dropped. When it targets a different page, both writes land.
- R11: `host_rdata` shows the key of `host_page` one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Absolute address of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 table read |
| req_flags | input | 3 | Incoming permissions: read, write, execute |
| mem_pages | input | ADDR_W-PAGE_BITS+1 | Configured storage size in pages |
| rsp_done | output | 1 | One-cycle pulse per request |
| rsp_flags | output | 3 | Resulting permissions, valid with rsp_done |
| host_page | input | log2(KEY_PAGES) | Page selected by the host port |
| host_we | input | 1 | Host key write enable |
| host_wdata | input | 8 | Key byte written by the host |
| host_rdata | output | 8 | Key byte of host_page, one cycle later |

## Verification
On every cycle the assertions check the response timing of R9 and that returned flags can only lose bits, never gain them. They also check that stores, skipped accesses and table reads do not alter flags or trigger write-back, and that a same-page host write overrides the update (R10). Only the directed scenarios can show the actual key contents after each kind of access. The same holds for the change-bit-dependent write removal, the exact memory-size and key-storage boundaries, and read-after-update ordering across back-to-back requests. These become visible through the host read port and the response flags.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_WALK  = 2'b11
  } acc_kind_e;

  localparam int KEY_W    = 8;
  localparam int FLAG_W   = 3;
  localparam int KB_REF   = 2;
  localparam int KB_CHG   = 1;
  localparam int FL_WRITE = 1;

  function automatic logic is_final_access(logic [1:0] kind);
    return kind != ACC_WALK;
  endfunction
endpackage

// File: rtl/skey_front.sv
module skey_front
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int KEY_PAGES = 64,
  localparam int PN_W     = ADDR_W - PAGE_BITS,
  localparam int KIDX_W   = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [FLAG_W-1:0] req_flags,
  input  logic [PN_W:0]     mem_pages,
  output logic              s1_valid,
  output logic [KIDX_W-1:0] s1_kidx,
  output logic [1:0]        s1_kind,
  output logic [FLAG_W-1:0] s1_flags,
  output logic              s1_skip,
  output logic              s1_err
);
  logic [PN_W-1:0]   pnum;
  logic              skip_d, err_d;
  logic [KIDX_W-1:0] kidx_d;

  always_comb begin
    pnum   = req_addr[ADDR_W-1:PAGE_BITS];
    skip_d = ({1'b0, pnum} >= mem_pages);
    err_d  = (pnum >= PN_W'(KEY_PAGES));
    kidx_d = pnum[KIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kidx  <= '0;
      s1_kind  <= '0;
      s1_flags <= '0;
      s1_skip  <= 1'b0;
      s1_err   <= 1'b0;
    end else if (req_valid) begin
      s1_kidx  <= kidx_d;
      s1_kind  <= req_kind;
      s1_flags <= req_flags;
      s1_skip  <= skip_d;
      s1_err   <= err_d;
    end
  end
endmodule

// File: rtl/skey_merge.sv
module skey_merge
  import skey_pkg::*;
(
  input  logic              s1_valid,
  input  logic [1:0]        s1_kind,
  input  logic [FLAG_W-1:0] s1_flags,
  input  logic              s1_skip,
  input  logic              s1_err,
  input  logic [KEY_W-1:0]  rd_key,
  output logic              wb_en,
  output logic [KEY_W-1:0]  wb_key,
  output logic [FLAG_W-1:0] out_flags
);
  logic upd, is_store;

  always_comb begin
    is_store  = (s1_kind == ACC_STORE);
    upd       = s1_valid && is_final_access(s1_kind) && !s1_skip && !s1_err;
    wb_en     = upd;
    wb_key    = rd_key;
    wb_key[KB_REF] = 1'b1;
    if (is_store) wb_key[KB_CHG] = 1'b1;
    out_flags = s1_flags;
    if (upd && !is_store && !rd_key[KB_CHG]) out_flags[FL_WRITE] = 1'b0;
  end
endmodule

// File: rtl/skey_array.sv
module skey_array
  import skey_pkg::*;
#(
  parameter int KEY_PAGES = 64,
  localparam int KIDX_W   = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KIDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0]  rd_key,
  input  logic              wb_en,
  input  logic [KIDX_W-1:0] wb_idx,
  input  logic [KEY_W-1:0]  wb_key,
  input  logic [KIDX_W-1:0] host_page,
  input  logic              host_we,
  input  logic [KEY_W-1:0]  host_wdata,
  output logic [KEY_W-1:0]  host_rdata
);
  logic [KEY_W-1:0] key_q [KEY_PAGES];

  for (genvar g = 0; g < KEY_PAGES; g++) begin : g_row
    logic             hit_host, hit_wb, row_en;
    logic [KEY_W-1:0] row_d;

    always_comb begin
      hit_host = host_we && (host_page == KIDX_W'(g));
      hit_wb   = wb_en && (wb_idx == KIDX_W'(g));
      row_en   = hit_host || hit_wb;
      row_d    = hit_host ? host_wdata : wb_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      key_q[g] <= '0;
      else if (row_en) key_q[g] <= row_d;
    end
  end

  assign rd_key = key_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= key_q[host_page];
  end

  a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && wb_en && host_page == wb_idx)
      |=> key_q[$past(host_page)] == $past(host_wdata));

  a_r4_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(host_we && host_page == wb_idx))
      |=> key_q[$past(wb_idx)] == $past(wb_key));

  a_r10_other_page_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && wb_en && host_page != wb_idx)
      |=> key_q[$past(host_page)] == $past(host_wdata));
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int KEY_PAGES = 64,
  localparam int PN_W     = ADDR_W - PAGE_BITS,
  localparam int KIDX_W   = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_flags,
  input  logic [PN_W:0]     mem_pages,
  output logic              rsp_done,
  output logic [2:0]        rsp_flags,
  input  logic [KIDX_W-1:0] host_page,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata
);
  logic              s1_valid, s1_skip, s1_err, wb_en;
  logic [KIDX_W-1:0] s1_kidx;
  logic [1:0]        s1_kind;
  logic [FLAG_W-1:0] s1_flags, out_flags;
  logic [KEY_W-1:0]  rd_key, wb_key;

  skey_front #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .KEY_PAGES(KEY_PAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_flags(req_flags), .mem_pages(mem_pages),
    .s1_valid(s1_valid), .s1_kidx(s1_kidx), .s1_kind(s1_kind),
    .s1_flags(s1_flags), .s1_skip(s1_skip), .s1_err(s1_err)
  );

  skey_merge u_merge (
    .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_flags(s1_flags),
    .s1_skip(s1_skip), .s1_err(s1_err), .rd_key(rd_key),
    .wb_en(wb_en), .wb_key(wb_key), .out_flags(out_flags)
  );

  skey_array #(.KEY_PAGES(KEY_PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_idx(s1_kidx), .rd_key(rd_key),
    .wb_en(wb_en), .wb_idx(s1_kidx), .wb_key(wb_key),
    .host_page(host_page), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_done <= 1'b0;
    else        rsp_done <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_flags <= '0;
    else if (s1_valid) rsp_flags <= out_flags;
  end

  a_r9_done_two_later: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_done);

  a_r9_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(s1_valid));

  a_r6_flags_only_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ((rsp_flags & ~$past(s1_flags)) == '0));

  a_r5_store_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == ACC_STORE) |=> rsp_flags == $past(s1_flags));

  a_r3_no_update_when_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_skip || s1_err || s1_kind == ACC_WALK)) |-> !wb_en);

  a_r8_walk_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == ACC_WALK) |=> rsp_flags == $past(s1_flags));
endmodule

// File: tb/skey_rc_updater_bench.sv
module skey_rc_updater_bench;
  localparam int ADDR_W = 32;
  localparam int PB     = 12;
  localparam int KP     = 64;
  localparam int PN_W   = ADDR_W - PB;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_kind = '0;
  logic [2:0]        req_flags = '0;
  logic [PN_W:0]     mem_pages = (PN_W+1)'(64);
  logic              rsp_done;
  logic [2:0]        rsp_flags;
  logic [5:0]        host_page = '0;
  logic              host_we = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  skey_rc_updater u_skey_rc_updater (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_flags(req_flags), .mem_pages(mem_pages),
    .rsp_done(rsp_done), .rsp_flags(rsp_flags), .host_page(host_page),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(int page, int off);
    return ADDR_W'((page << PB) | (off & 12'hfff));
  endfunction

  task automatic host_write(int page, logic [7:0] val);
    @(negedge clk);
    host_page = 6'(page); host_wdata = val; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic key_check(string tag, int page, logic [7:0] exp);
    @(negedge clk);
    host_page = 6'(page);
    @(negedge clk);
    check(tag, {24'd0, host_rdata}, {24'd0, exp});
  endtask

  task automatic access(string tag, logic [1:0] kind, int page, int off,
                        logic [2:0] fl, logic [2:0] exp_fl);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = mk_addr(page, off); req_flags = fl;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " done early"}, {31'd0, rsp_done}, 32'd0);
    @(negedge clk);
    check({tag, " done"}, {31'd0, rsp_done}, 32'd1);
    check({tag, " flags"}, {29'd0, rsp_flags}, {29'd0, exp_fl});
  endtask

  task automatic t_reset;
    check("R1 done", {31'd0, rsp_done}, 32'd0);
    check("R1 flags", {29'd0, rsp_flags}, 32'd0);
    check("R1 rdata", {24'd0, host_rdata}, 32'd0);
    key_check("R1 key page5", 5, 8'h00);
    key_check("R1 key page63", 63, 8'h00);
  endtask

  task automatic t_basic;
    host_write(3, 8'hA8);
    key_check("R11 host readback", 3, 8'hA8);
    access("R6 load clean", 2'b00, 3, 12'h123, 3'b111, 3'b101);
    key_check("R4 ref set", 3, 8'hAC);
    access("R5 store", 2'b01, 3, 12'hfff, 3'b111, 3'b111);
    key_check("R5 chg set", 3, 8'hAE);
    access("R6 load dirty", 2'b00, 3, 12'h000, 3'b111, 3'b111);
    access("R6 fetch clean", 2'b10, 7, 12'h004, 3'b110, 3'b100);
    key_check("R4 fetch ref", 7, 8'h04);
    access("R2 offset", 2'b00, 8, 12'hffc, 3'b011, 3'b001);
    key_check("R2 page8", 8, 8'h04);
    key_check("R2 page9 untouched", 9, 8'h00);
  endtask

  task automatic t_limit;
    mem_pages = (PN_W+1)'(16);
    access("R3 above limit", 2'b01, 20, 0, 3'b011, 3'b011);
    key_check("R3 page20 unchanged", 20, 8'h00);
    access("R3 at limit", 2'b00, 16, 0, 3'b011, 3'b011);
    key_check("R3 page16 unchanged", 16, 8'h00);
    access("R3 last page", 2'b01, 15, 0, 3'b011, 3'b011);
    key_check("R3 page15 updated", 15, 8'h06);
    mem_pages = (PN_W+1)'(200);
    access("R7 no key storage", 2'b00, 70, 0, 3'b011, 3'b011);
    key_check("R7 no alias page6", 6, 8'h00);
    mem_pages = (PN_W+1)'(64);
  endtask

  task automatic t_walk;
    access("R8 table read", 2'b11, 9, 0, 3'b111, 3'b111);
    key_check("R8 page9 unchanged", 9, 8'h00);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = mk_addr(10, 0); req_flags = 3'b111;
    @(negedge clk);
    req_kind = 2'b01; req_addr = mk_addr(10, 8);
    @(negedge clk);
    check("R9 b2b done1", {31'd0, rsp_done}, 32'd1);
    check("R9 b2b flags1", {29'd0, rsp_flags}, 32'd5);
    req_kind = 2'b00; req_addr = mk_addr(10, 16);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b done2", {31'd0, rsp_done}, 32'd1);
    check("R9 b2b flags2", {29'd0, rsp_flags}, 32'd7);
    @(negedge clk);
    check("R9 b2b done3", {31'd0, rsp_done}, 32'd1);
    check("R9 b2b flags3 sees chg", {29'd0, rsp_flags}, 32'd7);
    @(negedge clk);
    check("R9 single pulse", {31'd0, rsp_done}, 32'd0);
    key_check("R9 page10", 10, 8'h06);
  endtask

  task automatic t_collide;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_addr = mk_addr(12, 0); req_flags = 3'b111;
    @(negedge clk);
    req_valid = 1'b0;
    host_page = 6'd12; host_wdata = 8'h50; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    check("R10 collide flags", {29'd0, rsp_flags}, 32'd7);
    key_check("R10 host wins", 12, 8'h50);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_addr = mk_addr(13, 0); req_flags = 3'b111;
    @(negedge clk);
    req_valid = 1'b0;
    host_page = 6'd14; host_wdata = 8'h30; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    key_check("R10 update lands", 13, 8'h06);
    key_check("R10 host other page", 14, 8'h30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_limit();
    t_walk();
    t_b2b();
    t_collide();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule